// File: doc/BRIEF.md
# Multiword Double-Precision Shifter

This unit shifts one data word left or right by up to a full word width, in one of two fill modes. In zero-fill mode the vacated bit positions receive zeros. In secondary-fill mode they receive bits taken from a second input word: the upper bits of that word for a left shift, the lower bits for a right shift. Each operation also returns the unshifted primary word as a second result, together with the last bit pushed out of the primary word.

Because the second result is the original primary word, a chain of operations builds a shift wider than one word. The first step uses zero fill on the end word. Each later step uses secondary fill, with the previous step's second result as its secondary input. Feeding one value to both inputs in secondary-fill mode turns the shift into a rotate. There is no arithmetic right shift.

One strobe starts an operation, and all results appear registered on the following clock edge.

Top module: `msw_shifter`

## Requirements
- R1: With `dir_right`=0 and `fill_sec`=0, `prim_out` equals `prim_in` shifted left by the amount, with zeros in the vacated low bits.
- R2: For every operation, `sec_out` equals the `prim_in` value of that operation, whatever the mode, direction or amount.
- R3: With `dir_right`=0 and `fill_sec`=1, a shift by n puts the top n bits of `sec_in` into the low n bits of `prim_out`, in their original order. Chaining such steps gives a left shift of a multiword value.
- R4: With `dir_right`=1, bits move toward bit 0. Vacated top bits take zeros when `fill_sec`=0, so the sign bit is never copied. They take the low n bits of `sec_in` when `fill_sec`=1, which allows chained multiword right shifts.
- R5: An amount of 0 returns `prim_in` unchanged on `prim_out` and drives `bit_out` to 0.
- R6: An amount of 16 gives a `prim_out` of 0 in zero-fill mode and a `prim_out` equal to `sec_in` in secondary-fill mode. Amounts from 17 to 31 act as 16.
- R7: For an amount n of 1 to 16, `bit_out` is the last bit moved out of the primary word. For a left shift this is `prim_in[16-n]`; for a right shift it is `prim_in[n-1]`.
- R8: With `fill_sec`=1 and equal `prim_in` and `sec_in`, `prim_out` is that value rotated by the amount, to the left or to the right.
- R9: Results and a one-cycle `out_valid` pulse appear on the clock edge after the edge that samples `in_valid` high. While `in_valid` is low, `out_valid` stays low and the result outputs hold their values.
- R10: Synchronous reset drives `out_valid`, `prim_out`, `sec_out` and `bit_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts an operation on the operands present at this edge |
| prim_in | input | 16 | Word to be shifted |
| sec_in | input | 16 | Source of fill bits in secondary-fill mode |
| amount | input | 5 | Shift distance; values above 16 saturate to 16 |
| dir_right | input | 1 | 0 shifts left, 1 shifts right |
| fill_sec | input | 1 | 0 fills with zeros, 1 fills from `sec_in` |
| out_valid | output | 1 | One-cycle pulse marking new results |
| prim_out | output | 16 | Shifted primary result |
| sec_out | output | 16 | Copy of the operation's `prim_in` |
| bit_out | output | 1 | Last bit shifted out of the primary word |

## Verification
Two functions fall in the same cycle here: backing up the primary word into the second result, and drawing fill bits from the secondary input. In a rotate both draw on the same word.

The bench provokes this in two ways. It issues rotates with `prim_in` equal to `sec_in` at several amounts and in both directions. It also runs three-word chains, where each step's `sec_in` is the second result of the step before it.

Each rotate is judged against a rotation computed bit by bit in the bench. Each chain is judged against a 48-bit shift of the whole value. Both checks confirm that the fill was taken from the old secondary value, not from the backed-up primary.

// File: rtl/msw_pkg.sv
package msw_pkg;

    localparam int unsigned DEFAULT_W = 16;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SEC  = 1'b1
    } fill_e;

    function automatic int unsigned amt_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/msw_prep.sv
module msw_prep
    import msw_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 5,
    localparam int EXT_W = 2 * W + 1
) (
    input  logic [W-1:0]     prim,
    input  logic [W-1:0]     sec,
    input  logic [AW-1:0]    amount,
    input  dir_e             dir,
    input  fill_e            fill,
    output logic [EXT_W-1:0] ext,
    output logic [AW-1:0]    amt_sat
);

    logic [W-1:0] fill_word;
    logic [W-1:0] prim_rev;
    logic [W-1:0] fill_rev;
    logic [W-1:0] prim_or;
    logic [W-1:0] fill_or;

    always_comb begin
        fill_word = (fill == FILL_SEC) ? sec : '0;
    end

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign prim_rev[i] = prim[W-1-i];
        assign fill_rev[i] = fill_word[W-1-i];
    end

    always_comb begin
        if (dir == DIR_RIGHT) begin
            prim_or = prim;
            fill_or = fill_word;
        end else begin
            prim_or = prim_rev;
            fill_or = fill_rev;
        end
        ext = {fill_or, prim_or, 1'b0};
    end

    always_comb begin
        if (int'(amount) > W) amt_sat = AW'(W);
        else                  amt_sat = amount;
    end

endmodule

// File: rtl/msw_barrel.sv
module msw_barrel #(
    parameter int N     = 33,
    parameter int AW    = 5,
    parameter int OUT_W = 17
) (
    input  logic [N-1:0]     data,
    input  logic [AW-1:0]    amt,
    output logic [OUT_W-1:0] data_o
);

    logic [N-1:0] stage [AW+1];
    logic         unused_hi;

    assign stage[0] = data;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? (stage[s] >> STEP) : stage[s];
    end

    assign data_o    = stage[AW][OUT_W-1:0];
    assign unused_hi = ^stage[AW][N-1:OUT_W];

endmodule

// File: rtl/msw_finish.sv
module msw_finish
    import msw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]   shifted,
    input  dir_e         dir,
    output logic [W-1:0] prim_res,
    output logic         last_bit
);

    logic [W-1:0] win;
    logic [W-1:0] win_rev;

    assign win      = shifted[W:1];
    assign last_bit = shifted[0];

    for (genvar i = 0; i < W; i++) begin : g_unrev
        assign win_rev[i] = win[W-1-i];
    end

    always_comb begin
        prim_res = (dir == DIR_RIGHT) ? win : win_rev;
    end

endmodule

// File: rtl/msw_outreg.sv
module msw_outreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] prim_res,
    input  logic [W-1:0] sec_res,
    input  logic         last_bit,
    output logic         out_valid,
    output logic [W-1:0] prim_q,
    output logic [W-1:0] sec_q,
    output logic         bit_q
);

    typedef struct packed {
        logic [W-1:0] prim;
        logic [W-1:0] sec;
        logic         lbit;
    } result_t;

    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q.prim <= prim_res;
                res_q.sec  <= sec_res;
                res_q.lbit <= last_bit;
            end
        end
    end

    assign prim_q = res_q.prim;
    assign sec_q  = res_q.sec;
    assign bit_q  = res_q.lbit;

endmodule

// File: rtl/msw_shifter.sv
module msw_shifter
    import msw_pkg::*;
#(
    parameter int W = msw_pkg::DEFAULT_W,
    localparam int AW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  prim_in,
    input  logic [W-1:0]  sec_in,
    input  logic [AW-1:0] amount,
    input  logic          dir_right,
    input  logic          fill_sec,
    output logic          out_valid,
    output logic [W-1:0]  prim_out,
    output logic [W-1:0]  sec_out,
    output logic          bit_out
);

    localparam int EXT_W = 2 * W + 1;

    dir_e             dir;
    fill_e            fill;
    logic [EXT_W-1:0] ext;
    logic [AW-1:0]    amt_sat;
    logic [W:0]       shifted;
    logic [W-1:0]     prim_res;
    logic             last_bit;

    assign dir  = dir_e'(dir_right);
    assign fill = fill_e'(fill_sec);

    msw_prep #(.W(W), .AW(AW)) u_prep (
        .prim    (prim_in),
        .sec     (sec_in),
        .amount  (amount),
        .dir     (dir),
        .fill    (fill),
        .ext     (ext),
        .amt_sat (amt_sat)
    );

    msw_barrel #(.N(EXT_W), .AW(AW), .OUT_W(W + 1)) u_barrel (
        .data   (ext),
        .amt    (amt_sat),
        .data_o (shifted)
    );

    msw_finish #(.W(W)) u_finish (
        .shifted  (shifted),
        .dir      (dir),
        .prim_res (prim_res),
        .last_bit (last_bit)
    );

    msw_outreg #(.W(W)) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .prim_res  (prim_res),
        .sec_res   (prim_in),
        .last_bit  (last_bit),
        .out_valid (out_valid),
        .prim_q    (prim_out),
        .sec_q     (sec_out),
        .bit_q     (bit_out)
    );

endmodule

// File: rtl/msw_shifter_chk.sv
module msw_shifter_chk #(
    parameter int W = 16,
    localparam int AW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [W-1:0]  prim_in,
    input logic [W-1:0]  sec_in,
    input logic [AW-1:0] amount,
    input logic          dir_right,
    input logic          fill_sec,
    input logic          out_valid,
    input logic [W-1:0]  prim_out,
    input logic [W-1:0]  sec_out,
    input logic          bit_out
);

    function automatic logic [W-1:0] rot_left(input logic [W-1:0] v, input int n);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[(i + n) % W] = v[i];
        return r;
    endfunction

    // R2: second result is the operand's primary word
    a_r2_backup: assert property (@(posedge clk) disable iff (rst)
        (in_valid) |=> (sec_out == $past(prim_in)));

    // R5: zero amount passes the word through and outputs no bit
    a_r5_zero_amount: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amount == '0) |=> (prim_out == $past(prim_in) && !bit_out));

    // R6: full or saturated plain shift clears the word
    a_r6_plain_full: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fill_sec && int'(amount) >= W) |=> (prim_out == '0));

    // R6: full or saturated double shift returns the secondary word
    a_r6_double_full: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fill_sec && int'(amount) >= W) |=> (prim_out == $past(sec_in)));

    // R8: left rotate
    a_r8_rotate_left: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fill_sec && !dir_right && prim_in == sec_in && int'(amount) <= W)
        |=> (prim_out == rot_left($past(prim_in), int'($past(amount)))));

    // R8: right rotate
    a_r8_rotate_right: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fill_sec && dir_right && prim_in == sec_in && int'(amount) <= W)
        |=> (prim_out == rot_left($past(prim_in), W - int'($past(amount)))));

    // R9: strobe produces a valid pulse
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid) |=> out_valid);

    // R9: no strobe, no valid, held results
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> (!out_valid && $stable(prim_out) && $stable(sec_out) && $stable(bit_out)));

endmodule

bind msw_shifter msw_shifter_chk #(.W(W)) u_chk (.*);

// File: tb/msw_shifter_test.sv
module msw_shifter_test;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  prim_in = '0;
    logic [W-1:0]  sec_in = '0;
    logic [4:0]    amount = '0;
    logic          dir_right = 1'b0;
    logic          fill_sec = 1'b0;
    logic          out_valid;
    logic [W-1:0]  prim_out;
    logic [W-1:0]  sec_out;
    logic          bit_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msw_shifter uut (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .prim_in (prim_in), .sec_in (sec_in), .amount (amount),
        .dir_right (dir_right), .fill_sec (fill_sec),
        .out_valid (out_valid), .prim_out (prim_out),
        .sec_out (sec_out), .bit_out (bit_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bit-level reference shift, independent of the design structure
    task automatic model(input logic [W-1:0] p, input logic [W-1:0] s, input int n_in,
                         input bit right, input bit dbl,
                         output logic [W-1:0] res, output logic lb);
        int n;
        logic [W-1:0] f;
        n = (n_in > W) ? W : n_in;
        f = dbl ? s : '0;
        for (int i = 0; i < W; i++) begin
            int src;
            if (!right) begin
                src = i - n;
                res[i] = (src >= 0) ? p[src] : f[W + src];
            end else begin
                src = i + n;
                res[i] = (src < W) ? p[src] : f[src - W];
            end
        end
        if (n == 0)     lb = 1'b0;
        else if (!right) lb = p[W - n];
        else             lb = p[n - 1];
    endtask

    task automatic do_op(input logic [W-1:0] p, input logic [W-1:0] s, input int n,
                         input bit right, input bit dbl);
        @(negedge clk);
        prim_in   = p;
        sec_in    = s;
        amount    = 5'(n);
        dir_right = right;
        fill_sec  = dbl;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic op_check(input string req, input logic [W-1:0] p, input logic [W-1:0] s,
                            input int n, input bit right, input bit dbl);
        logic [W-1:0] er;
        logic eb;
        model(p, s, n, right, dbl, er, eb);
        do_op(p, s, n, right, dbl);
        check(req, "prim_out", prim_out, er);
        check("R2", "sec_out", sec_out, p);
        check("R7", "bit_out", {15'd0, bit_out}, {15'd0, eb});
        check("R9", "out_valid", {15'd0, out_valid}, 16'd1);
    endtask

    task automatic t_reset();
        check("R10", "prim_out", prim_out, '0);
        check("R10", "sec_out", sec_out, '0);
        check("R10", "bit_out", {15'd0, bit_out}, '0);
        check("R10", "out_valid", {15'd0, out_valid}, '0);
    endtask

    task automatic t_plain_left();
        op_check("R1", 16'hB5A3, 16'hFFFF, 1, 0, 0);
        op_check("R1", 16'hB5A3, 16'hFFFF, 7, 0, 0);
        op_check("R1", 16'h0001, 16'h1234, 15, 0, 0);
    endtask

    task automatic t_double_left();
        op_check("R3", 16'h1234, 16'hABCD, 4, 0, 1);
        op_check("R3", 16'h00FF, 16'hE000, 3, 0, 1);
        op_check("R3", 16'h5555, 16'h8001, 11, 0, 1);
    endtask

    task automatic t_right();
        op_check("R4", 16'h8000, 16'hFFFF, 1, 1, 0);
        check("R4", "no sign fill", prim_out, 16'h4000);
        op_check("R4", 16'hF00F, 16'h0000, 9, 1, 0);
        op_check("R4", 16'h1234, 16'h000B, 4, 1, 1);
        op_check("R4", 16'hC3C3, 16'h7E81, 13, 1, 1);
    endtask

    task automatic t_zero_amount();
        op_check("R5", 16'hDEAD, 16'hBEEF, 0, 0, 1);
        check("R5", "unchanged", prim_out, 16'hDEAD);
        check("R5", "bit zero", {15'd0, bit_out}, '0);
        op_check("R5", 16'h8001, 16'hFFFF, 0, 1, 0);
    endtask

    task automatic t_full_and_sat();
        op_check("R6", 16'hA5A5, 16'h3C3C, 16, 0, 0);
        check("R6", "plain full", prim_out, 16'h0000);
        op_check("R6", 16'hA5A5, 16'h3C3C, 16, 1, 1);
        check("R6", "double full", prim_out, 16'h3C3C);
        op_check("R6", 16'h8001, 16'h9876, 23, 0, 1);
        check("R6", "saturated", prim_out, 16'h9876);
        op_check("R6", 16'h8001, 16'h9876, 31, 1, 0);
        check("R6", "saturated plain", prim_out, 16'h0000);
    endtask

    task automatic t_last_bit();
        op_check("R7", 16'h0800, 16'h0000, 5, 0, 0);
        check("R7", "left last out", {15'd0, bit_out}, 16'd1);
        op_check("R7", 16'h0010, 16'h0000, 5, 1, 0);
        check("R7", "right last out", {15'd0, bit_out}, 16'd1);
    endtask

    task automatic t_rotate();
        op_check("R8", 16'h8123, 16'h8123, 4, 0, 1);
        check("R8", "rotl 4", prim_out, 16'h1238);
        op_check("R8", 16'h8123, 16'h8123, 4, 1, 1);
        check("R8", "rotr 4", prim_out, 16'h3812);
        op_check("R8", 16'h0001, 16'h0001, 15, 0, 1);
        check("R8", "rotl 15", prim_out, 16'h8000);
    endtask

    task automatic t_chain();
        logic [47:0] v, e;
        logic [W-1:0] w0, w1, w2, carry;
        v = 48'h9ABC_DEF0_1357;
        e = v << 9;
        do_op(v[15:0], 16'h0, 9, 0, 0);  w0 = prim_out; carry = sec_out;
        do_op(v[31:16], carry, 9, 0, 1); w1 = prim_out; carry = sec_out;
        do_op(v[47:32], carry, 9, 0, 1); w2 = prim_out;
        check("R3", "chain left", w0, e[15:0]);
        check("R3", "chain left", w1, e[31:16]);
        check("R3", "chain left", w2, e[47:32]);
        e = v >> 5;
        do_op(v[47:32], 16'h0, 5, 1, 0); w2 = prim_out; carry = sec_out;
        do_op(v[31:16], carry, 5, 1, 1); w1 = prim_out; carry = sec_out;
        do_op(v[15:0], carry, 5, 1, 1);  w0 = prim_out;
        check("R4", "chain right", w0, e[15:0]);
        check("R4", "chain right", w1, e[31:16]);
        check("R4", "chain right", w2, e[47:32]);
    endtask

    task automatic t_hold();
        logic [W-1:0] hp, hs;
        logic hb;
        op_check("R9", 16'h7F01, 16'h0000, 3, 0, 0);
        hp = prim_out; hs = sec_out; hb = bit_out;
        @(negedge clk);
        prim_in = 16'hFFFF; sec_in = 16'hFFFF; amount = 5'd2; fill_sec = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", "idle valid", {15'd0, out_valid}, '0);
        check("R9", "hold prim", prim_out, hp);
        check("R9", "hold sec", sec_out, hs);
        check("R9", "hold bit", {15'd0, bit_out}, {15'd0, hb});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_left();
        t_double_left();
        t_right();
        t_zero_amount();
        t_full_and_sat();
        t_last_bit();
        t_rotate();
        t_chain();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule